// File: doc/BRIEF.md
# Half-Port Pin Interrupt Controller

This block collects interrupt requests from external pins and presents them as one interrupt channel that is 32 inputs wide. The pins arrive as a set of 8-pin half ports. Each of the channel's four 8-bit lanes is fed by one half port, and a small select field per lane picks which one. Pins are never chosen one at a time.

Each of the 32 channel bits has its own settings. It can sense an edge or a level, and its polarity can be inverted. It keeps a request latch and has a mask bit. The mask, sense-mode and polarity registers each have one address that sets bits and another that clears them. A write therefore touches only the bits written as one. The latch and the routed pin levels can always be read, whether or not a bit is masked. The masked view of the latches is combined into a single interrupt output.

Software programs the block through a simple single-cycle register port. Writes are synchronous. Reads are combinational from the read address.

Top module: `hp_pin_irq`

## Requirements
- R1: After reset, the mask, sense-mode and polarity registers are all zero, so every bit is in level mode with normal polarity. Lane L selects half port L, so the assign register reads 0xE4 with the default parameters, and irq_o is low.
- R2: Lane L (channel bits 8L+7..8L) carries half port h, which is pins_i[8h+7:8h], where h is the 2-bit select field at bits 2L+1:2L of the assign register (address 9). Reading address 8 returns the routed, unmodified pin levels.
- R3: Writing to address 0 sets the mask bits written as one, and writing to address 1 clears them. Addresses 2 and 3 do the same for the sense-mode register (1 = edge), and addresses 4 and 5 do the same for the polarity register (1 = inverted). Bits written as zero keep their value, and either address of a pair reads back the register.
- R4: The effective input of each bit is its routed pin XOR its polarity bit.
- R5: In edge mode, a rising transition of the effective input sets the latch bit one clock later. The bit then stays set after the input falls.
- R6: In level mode, the latch bit takes the effective input of the previous cycle.
- R7: Writing a one to a bit at address 6 clears that latch bit. If a new edge on that bit arrives in the same cycle, the edge wins and the bit stays set.
- R8: Address 6 returns the latches whatever the mask holds. Address 7 returns the latches ANDed with the mask.
- R9: irq_o is high exactly when some bit is both latched and unmasked.
- R10: Writing the assign register with a new select value for a lane clears that lane's latches at the same edge. The switch itself never counts as an edge, and lanes whose select value does not change keep their latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | External pins, four half ports of 8 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Channel interrupt request |

## Verification
The bench builds the block with its default parameters: four half ports, four lanes of eight bits, and 2-bit select fields. With these values, every lane can reach every half port. Routing can be checked with crossed and repeated assignments, and a lane can be switched onto a half port whose pins are already high, which exercises the spurious-edge suppression. A 32-bit channel also lets edge and level bits, masked and unmasked bits, and a clear that races an edge all be placed in separate lanes and checked in the same register read.

// File: rtl/hp_pin_irq_pkg.sv
package hp_pin_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_SET = 4'h0,
    A_MASK_CLR = 4'h1,
    A_EDGE_SET = 4'h2,
    A_EDGE_CLR = 4'h3,
    A_POL_SET  = 4'h4,
    A_POL_CLR  = 4'h5,
    A_LATCH    = 4'h6,
    A_REQ      = 4'h7,
    A_PIN      = 4'h8,
    A_ASSIGN   = 4'h9
  } reg_addr_e;
endpackage

// File: rtl/hp_lane_route.sv
module hp_lane_route #(
  parameter int NUM_HP = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_HP*LANE_W-1:0] pins_i,
  input  logic [LANES*SEL_W-1:0]   sel_i,
  output logic [LANES*LANE_W-1:0]  lane_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mux;
    always_comb begin
      mux = '0;
      for (int h = 0; h < NUM_HP; h++) begin
        if (sel_i[l*SEL_W +: SEL_W] == SEL_W'(h)) mux = pins_i[h*LANE_W +: LANE_W];
      end
    end
    assign lane_o[l*LANE_W +: LANE_W] = mux;
  end
endmodule

// File: rtl/hp_pin_regs.sv
module hp_pin_regs
  import hp_pin_irq_pkg::*;
#(
  parameter int NUM_HP = 4,
  parameter int LANES  = 4,
  parameter int SEL_W  = 2,
  parameter int N      = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [N-1:0]           wr_data_i,
  output logic [N-1:0]           mask_o,
  output logic [N-1:0]           edge_mode_o,
  output logic [N-1:0]           pol_o,
  output logic [LANES*SEL_W-1:0] sel_o,
  output logic [N-1:0]           clr_o,
  output logic [LANES-1:0]       chg_o
);
  localparam int SW = LANES * SEL_W;

  function automatic logic [SW-1:0] sel_init();
    logic [SW-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) r[l*SEL_W +: SEL_W] = SEL_W'(l % NUM_HP);
    return r;
  endfunction

  logic [N-1:0]  mask_q, edge_q, pol_q;
  logic [SW-1:0] sel_q;
  logic          wr_assign;

  assign wr_assign = wr_en_i && (wr_addr_i == A_ASSIGN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      sel_q  <= sel_init();
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MASK_SET: mask_q <= mask_q | wr_data_i;
        A_MASK_CLR: mask_q <= mask_q & ~wr_data_i;
        A_EDGE_SET: edge_q <= edge_q | wr_data_i;
        A_EDGE_CLR: edge_q <= edge_q & ~wr_data_i;
        A_POL_SET:  pol_q  <= pol_q | wr_data_i;
        A_POL_CLR:  pol_q  <= pol_q & ~wr_data_i;
        A_ASSIGN:   sel_q  <= wr_data_i[SW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_chg
    assign chg_o[l] = wr_assign &&
                      (wr_data_i[l*SEL_W +: SEL_W] != sel_q[l*SEL_W +: SEL_W]);
  end

  assign clr_o       = (wr_en_i && (wr_addr_i == A_LATCH)) ? wr_data_i : '0;
  assign mask_o      = mask_q;
  assign edge_mode_o = edge_q;
  assign pol_o       = pol_q;
  assign sel_o       = sel_q;
endmodule

// File: rtl/hp_pin_detect.sv
module hp_pin_detect #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] eff_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] flush_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] latch_o
);
  logic [N-1:0] eff_q, flush_q, latch_q;

  // cycle after a lane switch compares against the old half port: ignore it
  assign rise_o = eff_i & ~eff_q & ~flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q   <= '0;
      flush_q <= '0;
      latch_q <= '0;
    end else begin
      eff_q   <= eff_i;
      flush_q <= flush_i;
      for (int i = 0; i < N; i++) begin
        if (flush_i[i])           latch_q[i] <= 1'b0;
        else if (!edge_mode_i[i]) latch_q[i] <= eff_i[i];
        else                      latch_q[i] <= (latch_q[i] & ~clr_i[i]) | rise_o[i];
      end
    end
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/hp_pin_irq.sv
module hp_pin_irq
  import hp_pin_irq_pkg::*;
#(
  parameter int NUM_HP = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int N     = LANES * LANE_W,
  localparam int SEL_W = (NUM_HP > 1) ? $clog2(NUM_HP) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_HP*LANE_W-1:0] pins_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [N-1:0]            wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [N-1:0]            rd_data_o,
  output logic                    irq_o
);
  logic [N-1:0]           mask, edge_mode, pol, clr, flush, rise, latch, lane, eff, req;
  logic [LANES*SEL_W-1:0] sel;
  logic [LANES-1:0]       chg;

  hp_pin_regs #(.NUM_HP(NUM_HP), .LANES(LANES), .SEL_W(SEL_W), .N(N)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mask_o(mask), .edge_mode_o(edge_mode), .pol_o(pol),
    .sel_o(sel), .clr_o(clr), .chg_o(chg)
  );

  hp_lane_route #(.NUM_HP(NUM_HP), .LANES(LANES), .LANE_W(LANE_W), .SEL_W(SEL_W)) route_i (
    .pins_i, .sel_i(sel), .lane_o(lane)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_flush
    assign flush[l*LANE_W +: LANE_W] = {LANE_W{chg[l]}};
  end

  assign eff = lane ^ pol;

  hp_pin_detect #(.N(N)) det_i (
    .clk_i, .rst_ni, .eff_i(eff), .edge_mode_i(edge_mode),
    .clr_i(clr), .flush_i(flush), .rise_o(rise), .latch_o(latch)
  );

  assign req   = latch & mask;
  assign irq_o = |req;

  always_comb begin
    case (rd_addr_i)
      A_MASK_SET, A_MASK_CLR: rd_data_o = mask;
      A_EDGE_SET, A_EDGE_CLR: rd_data_o = edge_mode;
      A_POL_SET,  A_POL_CLR:  rd_data_o = pol;
      A_LATCH:                rd_data_o = latch;
      A_REQ:                  rd_data_o = req;
      A_PIN:                  rd_data_o = lane;
      A_ASSIGN:               rd_data_o = N'(sel);
      default:                rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/hp_pin_irq_chk.sv
module hp_pin_irq_chk #(
  parameter int N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         set_mask_i,
  input logic [N-1:0] wr_data_i,
  input logic [N-1:0] mask_i,
  input logic [N-1:0] edge_mode_i,
  input logic [N-1:0] eff_i,
  input logic [N-1:0] clr_i,
  input logic [N-1:0] flush_i,
  input logic [N-1:0] rise_i,
  input logic [N-1:0] latch_i
);
  logic         vld, setm_d;
  logic [N-1:0] data_d, eff_d, lvl_d, keep_d, clrhit_d, flush_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld <= 1'b0; setm_d <= 1'b0; data_d <= '0; eff_d <= '0;
      lvl_d <= '0; keep_d <= '0; clrhit_d <= '0; flush_d <= '0;
    end else begin
      vld      <= 1'b1;
      setm_d   <= set_mask_i;
      data_d   <= wr_data_i;
      eff_d    <= eff_i;
      lvl_d    <= ~edge_mode_i & ~flush_i;
      keep_d   <= latch_i & edge_mode_i & ~clr_i & ~flush_i;
      clrhit_d <= clr_i & edge_mode_i & ~rise_i & ~flush_i;
      flush_d  <= flush_i;
    end
  end

  // R3
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && setm_d) |-> ((mask_i & data_d) == data_d));
  // R5
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> ((keep_d & ~latch_i) == '0));
  // R6
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> (((latch_i ^ eff_d) & lvl_d) == '0));
  // R7
  latch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> ((clrhit_d & latch_i) == '0));
  // R10
  lane_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> ((flush_d & latch_i) == '0));
endmodule

bind hp_pin_irq hp_pin_irq_chk #(.N(N)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .set_mask_i(wr_en_i && (wr_addr_i == hp_pin_irq_pkg::A_MASK_SET)),
  .wr_data_i(wr_data_i), .mask_i(mask), .edge_mode_i(edge_mode), .eff_i(eff),
  .clr_i(clr), .flush_i(flush), .rise_i(rise), .latch_i(latch)
);

// File: tb/hp_pin_irq_tb_top.sv
module hp_pin_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hp_pin_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic set_pins(logic [31:0] p);
    @(negedge clk);
    pins = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); check("R1 mask", d, 32'h0);
    rd(4'h2, d); check("R1 edge", d, 32'h0);
    rd(4'h4, d); check("R1 pol", d, 32'h0);
    rd(4'h9, d); check("R1 assign", d, 32'hE4);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    set_pins(32'h44332211);
    rd(4'h8, d); check("R2 default route", d, 32'h44332211);
    wr(4'h9, 32'h63);
    rd(4'h8, d); check("R2 crossed route", d, 32'h22331144);
    wr(4'h9, 32'h00);
    rd(4'h8, d); check("R2 all lanes hp0", d, 32'h11111111);
    wr(4'h9, 32'hE4);
    set_pins(32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(4'h0, 32'h000000F0);
    wr(4'h0, 32'h0F000000);
    wr(4'h1, 32'h00000030);
    rd(4'h0, d); check("R3 mask set/clr", d, 32'h0F0000C0);
    rd(4'h1, d); check("R3 mask read at clr addr", d, 32'h0F0000C0);
    wr(4'h2, 32'hA5A5A5A5);
    wr(4'h3, 32'h0000FFFF);
    rd(4'h3, d); check("R3 edge set/clr", d, 32'hA5A50000);
    wr(4'h4, 32'h00FF0000);
    wr(4'h5, 32'h000F0000);
    rd(4'h4, d); check("R3 pol set/clr", d, 32'h00F00000);
    wr(4'h1, 32'hFFFFFFFF);
    wr(4'h3, 32'hFFFFFFFF);
    wr(4'h5, 32'hFFFFFFFF);
    rd(4'h0, d); check("R3 mask cleared", d, 32'h0);
  endtask

  task automatic t_level_pol();
    logic [31:0] d;
    set_pins(32'h00000020);
    rd(4'h6, d); check("R6 level latch follows", d, 32'h00000020);
    wr(4'h4, 32'h00000060);
    @(posedge clk); @(negedge clk);
    rd(4'h6, d); check("R4 polarity inverts", d, 32'h00000040);
    wr(4'h5, 32'hFFFFFFFF);
    set_pins(32'h0);
    @(posedge clk); @(negedge clk);
    rd(4'h6, d); check("R6 level latch falls", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(4'h2, 32'hFFFFFFFF);
    set_pins(32'h00000200);
    rd(4'h6, d); check("R5 rise sets latch", d, 32'h00000200);
    set_pins(32'h0);
    rd(4'h6, d); check("R5 latch holds after fall", d, 32'h00000200);
    rd(4'h7, d); check("R8 request masked off", d, 32'h0);
    check("R9 irq low while masked", {31'h0, irq}, 32'h0);
    wr(4'h0, 32'h00000200);
    rd(4'h7, d); check("R8 request unmasked", d, 32'h00000200);
    check("R9 irq high", {31'h0, irq}, 32'h1);
    wr(4'h6, 32'h00000200);
    rd(4'h6, d); check("R7 w1c clears", d, 32'h0);
    check("R9 irq low after clear", {31'h0, irq}, 32'h0);
    wr(4'h1, 32'hFFFFFFFF);
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    set_pins(32'h00003000);
    set_pins(32'h0);
    @(negedge clk);
    pins = 32'h00001000;
    wr_en = 1'b1; wr_addr = 4'h6; wr_data = 32'h00003000;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd(4'h6, d); check("R7 edge beats clear", d, 32'h00001000);
    set_pins(32'h0);
    wr(4'h6, 32'hFFFFFFFF);
  endtask

  task automatic t_assign();
    logic [31:0] d;
    set_pins(32'hFF000000);
    wr(4'h6, 32'hFFFFFFFF);
    rd(4'h6, d); check("R7 clear with pins high", d, 32'h0);
    set_pins(32'hFF010001);
    set_pins(32'hFF000000);
    rd(4'h6, d); check("R5 lanes 0 and 2 latched", d, 32'h00010001);
    wr(4'h9, 32'hE7);
    rd(4'h6, d); check("R10 switched lane flushed", d, 32'h00010000);
    @(posedge clk); @(negedge clk);
    rd(4'h6, d); check("R10 no edge from switch", d, 32'h00010000);
    rd(4'h8, d); check("R2 lane0 on hp3", d, 32'hFF0000FF);
    set_pins(32'h0);
    wr(4'h9, 32'hE4);
    wr(4'h6, 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_setclr();
    t_level_pol();
    t_edge();
    t_clear_race();
    t_assign();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule